// File: doc/BRIEF.md
# Loop and Conditional Branch Decision Unit

This unit settles the control-flow outcome of one branch-class operation at a time. The operation can be a counted-loop step or a test of the condition codes. A single-cycle strobe delivers the operands: an operation code, an operand size, the current flags, the loop operands (index, step and limit), an already sign-extended displacement and the current program counter. One clock later the unit presents four results, all registered: whether the branch is taken, the next program counter, the updated index with its new flags, and an overflow indication.

There are two loop forms. The first adds a signed step to the index and compares the result with the limit; the sign of the step picks the direction of the compare. The second adds one to the index and tests it against the limit with either a strict or a non-strict compare. Each loop form works at byte, word or longword width. The flag branches test one or two of the negative, zero, overflow and carry flags. The low-bit branches test bit 0 of a source word. Fetching operands, handling floating-point forms and delivering exceptions are left to the surrounding pipeline.

Top module: `loop_branch_unit`

## Requirements
- R1: The results appear on the outputs, with `out_valid` high for exactly one cycle, on the clock edge that follows the cycle in which `in_valid` is high. While `in_valid` is low, every result output holds its last value.
- R2: Operation code 0 (step-and-compare loop) computes new index = index + step. The branch is taken when the step is non-negative and the new index is less than or equal to the limit, or when the step is negative and the new index is greater than or equal to the limit. All compares are signed.
- R3: Operation codes 1 and 2 (increment loops) compute new index = index + 1. Code 1 branches when the new index is strictly below the limit. Code 2 branches when the new index is at or below the limit.
- R4: `in_size` 0, 1 and 2 select 8-, 16- and 32-bit operation. Index, step and limit use only their low bits at that width, and their upper bits are ignored. The compare is signed at that width. `out_index` is the width-sized result, sign-extended to 32 bits.
- R5: A loop update overflows when the two addends have the same sign and the width-sized sum has the other sign. The wrapped low-order sum is still kept. Overflow drives both `out_ovf` and the V flag.
- R6: After a loop operation, N is set when the new index is negative, Z is set when it is zero, V follows R5, and C keeps its input value. The flag vectors are ordered {N,Z,V,C}, with N in bit 3 and C in bit 0.
- R7: Signed flag branches: code 3 branches when Z=0, code 4 when Z=1, code 5 when (N|Z)=0, code 6 when (N|Z)=1, code 7 when N=0, and code 8 when N=1.
- R8: Unsigned and single-flag branches: code 9 branches when (C|Z)=0, code 10 when (C|Z)=1, code 11 when V=0, code 12 when V=1, code 13 when C=0, and code 14 when C=1.
- R9: Low-bit branches test bit 0 of `in_index`. Code 15 branches when that bit is 1, and code 16 branches when it is 0.
- R10: Codes 3 to 16 pass the flags through unchanged, pass `in_index` through unchanged, and hold `out_ovf` at 0.
- R11: When the branch is taken, the next PC is PC + displacement, modulo 2^32. When it is not taken, the next PC is the PC.
- R12: Reset clears every output to zero. Codes 17 to 31 are reserved: they are never taken and behave like R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle operation strobe |
| in_op | input | 5 | Operation code (see R2, R3, R7 to R9, R12) |
| in_size | input | 2 | Operand width: 0 byte, 1 word, 2 longword |
| in_cc | input | 4 | Current flags {N,Z,V,C} |
| in_index | input | 32 | Loop index, or the source for the low-bit branches |
| in_step | input | 32 | Signed step for code 0 |
| in_limit | input | 32 | Loop limit |
| in_disp | input | 32 | Sign-extended branch displacement |
| in_pc | input | 32 | Current program counter |
| out_valid | output | 1 | Result strobe |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | 32 | Next program counter |
| out_index | output | 32 | Updated index, sign-extended |
| out_cc | output | 4 | New flags {N,Z,V,C} |
| out_ovf | output | 1 | Loop index overflow |

## Verification
Every result is registered exactly once. A wrong alignment shift, a wrong compare direction or a wrong flag decode therefore shows up on `out_taken`, `out_index` or `out_cc` in the cycle right after the strobe. Nothing inside the unit survives from one operation to the next, so a fault cannot stay hidden: one operation that exercises it is enough to expose it. An error in the size decode shows up as an index that is not sign-extended, or as a compare result that changes when upper operand bits that should be ignored are changed. A broken hold path shows up as results that change while no strobe is present.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

    typedef enum logic [4:0] {
        OP_STEP_CMP = 5'd0,
        OP_INC_LT   = 5'd1,
        OP_INC_LE   = 5'd2,
        OP_NE       = 5'd3,
        OP_EQ       = 5'd4,
        OP_GT       = 5'd5,
        OP_LE       = 5'd6,
        OP_GE       = 5'd7,
        OP_LT       = 5'd8,
        OP_GTU      = 5'd9,
        OP_LEU      = 5'd10,
        OP_VCLR     = 5'd11,
        OP_VSET     = 5'd12,
        OP_CCLR     = 5'd13,
        OP_CSET     = 5'd14,
        OP_LBSET    = 5'd15,
        OP_LBCLR    = 5'd16
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } size_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    function automatic logic is_loop_op(input logic [4:0] op);
        return op <= 5'd2;
    endfunction

    function automatic logic is_flag_op(input logic [4:0] op);
        return (op >= 5'd3) && (op <= 5'd16);
    endfunction

endpackage

// File: rtl/lbr_arith.sv
module lbr_arith
    import lbr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   size,
    input  logic [W-1:0] index,
    input  logic [W-1:0] step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] result,
    output logic         ovf,
    output logic         neg,
    output logic         zero,
    output logic         step_neg,
    output logic         res_le,
    output logic         res_lt,
    output logic         res_ge
);
    localparam int SHW     = $clog2(W) + 1;
    localparam int SH_BYTE = W - 8;
    localparam int SH_WORD = W - 16;

    logic [SHW-1:0] sh;
    logic [W-1:0]   a_idx, a_step, a_lim, a_sum;

    // Operands are moved up so their sign bit sits at the top of the
    // word; the full-width adder and comparator then act at the chosen width.
    always_comb begin
        case (size_e'(size))
            SZ_BYTE: sh = SHW'(SH_BYTE);
            SZ_WORD: sh = SHW'(SH_WORD);
            default: sh = '0;
        endcase
        a_idx    = index << sh;
        a_step   = step << sh;
        a_lim    = limit << sh;
        a_sum    = a_idx + a_step;
        ovf      = (a_idx[W-1] == a_step[W-1]) && (a_sum[W-1] != a_idx[W-1]);
        result   = W'($signed(a_sum) >>> sh);
        neg      = a_sum[W-1];
        zero     = (a_sum == '0);
        step_neg = a_step[W-1];
        res_le   = $signed(a_sum) <= $signed(a_lim);
        res_lt   = $signed(a_sum) <  $signed(a_lim);
        res_ge   = $signed(a_sum) >= $signed(a_lim);
    end
endmodule

// File: rtl/lbr_cond.sv
module lbr_cond
    import lbr_pkg::*;
(
    input  logic [4:0] op,
    input  flags_t     cc,
    input  logic       low_bit,
    output logic       take
);
    always_comb begin
        case (op_e'(op))
            OP_NE:    take = ~cc.z;
            OP_EQ:    take =  cc.z;
            OP_GT:    take = ~(cc.n | cc.z);
            OP_LE:    take =  (cc.n | cc.z);
            OP_GE:    take = ~cc.n;
            OP_LT:    take =  cc.n;
            OP_GTU:   take = ~(cc.c | cc.z);
            OP_LEU:   take =  (cc.c | cc.z);
            OP_VCLR:  take = ~cc.v;
            OP_VSET:  take =  cc.v;
            OP_CCLR:  take = ~cc.c;
            OP_CSET:  take =  cc.c;
            OP_LBSET: take =  low_bit;
            OP_LBCLR: take = ~low_bit;
            default:  take = 1'b0;
        endcase
    end
endmodule

// File: rtl/lbr_target.sv
module lbr_target #(
    parameter int PCW = 32
) (
    input  logic [PCW-1:0] pc,
    input  logic [PCW-1:0] disp,
    input  logic           take,
    output logic [PCW-1:0] next_pc
);
    logic [PCW-1:0] branch_pc;
    assign branch_pc = pc + disp;
    assign next_pc   = take ? branch_pc : pc;
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
    import lbr_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int PCW  = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [4:0]      in_op,
    input  logic [1:0]      in_size,
    input  logic [3:0]      in_cc,
    input  logic [XLEN-1:0] in_index,
    input  logic [XLEN-1:0] in_step,
    input  logic [XLEN-1:0] in_limit,
    input  logic [PCW-1:0]  in_disp,
    input  logic [PCW-1:0]  in_pc,
    output logic            out_valid,
    output logic            out_taken,
    output logic [PCW-1:0]  out_next_pc,
    output logic [XLEN-1:0] out_index,
    output logic [3:0]      out_cc,
    output logic            out_ovf
);
    typedef struct packed {
        logic            taken;
        logic [PCW-1:0]  next_pc;
        logic [XLEN-1:0] index;
        flags_t          cc;
        logic            ovf;
    } result_t;

    flags_t          cc_in;
    logic [XLEN-1:0] step_eff;
    logic [XLEN-1:0] sum;
    logic            ovf, neg, zero, step_neg, res_le, res_lt, res_ge;
    logic            flag_take, loop_take, take;
    result_t         nxt, cur;
    logic            valid_q;

    assign cc_in    = flags_t'(in_cc);
    assign step_eff = (in_op == OP_STEP_CMP) ? in_step : XLEN'(1);

    lbr_arith #(.W(XLEN)) u_arith (
        .size     (in_size),
        .index    (in_index),
        .step     (step_eff),
        .limit    (in_limit),
        .result   (sum),
        .ovf      (ovf),
        .neg      (neg),
        .zero     (zero),
        .step_neg (step_neg),
        .res_le   (res_le),
        .res_lt   (res_lt),
        .res_ge   (res_ge)
    );

    lbr_cond u_cond (
        .op      (in_op),
        .cc      (cc_in),
        .low_bit (in_index[0]),
        .take    (flag_take)
    );

    always_comb begin
        case (op_e'(in_op))
            OP_STEP_CMP: loop_take = step_neg ? res_ge : res_le;
            OP_INC_LT:   loop_take = res_lt;
            OP_INC_LE:   loop_take = res_le;
            default:     loop_take = 1'b0;
        endcase
    end

    assign take = is_loop_op(in_op) ? loop_take : flag_take;

    lbr_target #(.PCW(PCW)) u_target (
        .pc      (in_pc),
        .disp    (in_disp),
        .take    (take),
        .next_pc (nxt.next_pc)
    );

    always_comb begin
        nxt.taken = take;
        if (is_loop_op(in_op)) begin
            nxt.index = sum;
            nxt.cc    = '{n: neg, z: zero, v: ovf, c: cc_in.c};
            nxt.ovf   = ovf;
        end else begin
            nxt.index = in_index;
            nxt.cc    = cc_in;
            nxt.ovf   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                cur <= nxt;
            end
        end
    end

    assign out_valid   = valid_q;
    assign out_taken   = cur.taken;
    assign out_next_pc = cur.next_pc;
    assign out_index   = cur.index;
    assign out_cc      = cur.cc;
    assign out_ovf     = cur.ovf;
endmodule

// File: rtl/lbr_checker.sv
module lbr_checker #(
    parameter int XLEN = 32,
    parameter int PCW  = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [4:0]      in_op,
    input logic [3:0]      in_cc,
    input logic [PCW-1:0]  in_disp,
    input logic [PCW-1:0]  in_pc,
    input logic            out_valid,
    input logic            out_taken,
    input logic [PCW-1:0]  out_next_pc,
    input logic [3:0]      out_cc,
    input logic            out_ovf
);
    logic loop_op, flag_op;
    assign loop_op = (in_op <= 5'd2);
    assign flag_op = (in_op >= 5'd3) && (in_op <= 5'd16);

    assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_strobe_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_carry_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && loop_op) |=> (out_cc[0] == $past(in_cc[0])));
    assert_flags_unchanged_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && flag_op) |=> (out_cc == $past(in_cc) && !out_ovf));
    assert_reserved_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !loop_op && !flag_op) |=> (!out_taken && !out_ovf));
    assert_target_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_next_pc == (out_taken ? $past(in_pc) + $past(in_disp)
                                                : $past(in_pc))));
    assert_ovf_matches_v_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && loop_op) |=> (out_ovf == out_cc[1]));
endmodule

bind loop_branch_unit lbr_checker #(.XLEN(XLEN), .PCW(PCW)) u_lbr_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .in_cc       (in_cc),
    .in_disp     (in_disp),
    .in_pc       (in_pc),
    .out_valid   (out_valid),
    .out_taken   (out_taken),
    .out_next_pc (out_next_pc),
    .out_cc      (out_cc),
    .out_ovf     (out_ovf)
);

// File: tb/loop_branch_unit_test.sv
`timescale 1ns/1ps
module loop_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  in_op = '0;
    logic [1:0]  in_size = '0;
    logic [3:0]  in_cc = '0;
    logic [31:0] in_index = '0, in_step = '0, in_limit = '0, in_disp = '0, in_pc = '0;
    logic        out_valid, out_taken, out_ovf;
    logic [31:0] out_next_pc, out_index;
    logic [3:0]  out_cc;

    int checks = 0;
    int failures = 0;

    logic        e_taken, e_ovf;
    logic [31:0] e_pc, e_idx;
    logic [3:0]  e_cc;

    always #2.5 clk = ~clk;

    loop_branch_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_size(in_size),
        .in_cc(in_cc), .in_index(in_index), .in_step(in_step), .in_limit(in_limit),
        .in_disp(in_disp), .in_pc(in_pc), .out_valid(out_valid), .out_taken(out_taken),
        .out_next_pc(out_next_pc), .out_index(out_index), .out_cc(out_cc), .out_ovf(out_ovf)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint sx(input longint v, input int w);
        longint r;
        r = v & ((longint'(1) << w) - 1);
        if (r >= (longint'(1) << (w - 1))) r = r - (longint'(1) << w);
        return r;
    endfunction

    task automatic model(input logic [4:0] op, input logic [1:0] sz, input logic [3:0] cc,
                         input logic [31:0] idx, input logic [31:0] stp, input logic [31:0] lim,
                         input logic [31:0] disp, input logic [31:0] pc);
        int w;
        longint si, sa, sl, sum, wr;
        logic n, z, v, c;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        {n, z, v, c} = cc;
        if (op <= 5'd2) begin
            si  = sx(longint'(idx), w);
            sl  = sx(longint'(lim), w);
            sa  = (op == 5'd0) ? sx(longint'(stp), w) : 1;
            sum = si + sa;
            wr  = sx(sum, w);
            e_ovf = (sum != wr);
            if (op == 5'd0)      e_taken = (sa >= 0) ? (wr <= sl) : (wr >= sl);
            else if (op == 5'd1) e_taken = (wr < sl);
            else                 e_taken = (wr <= sl);
            e_idx = wr[31:0];
            e_cc  = {wr < 0, wr == 0, e_ovf, c};
        end else begin
            e_idx = idx;
            e_cc  = cc;
            e_ovf = 1'b0;
            case (op)
                5'd3:  e_taken = !z;
                5'd4:  e_taken = z;
                5'd5:  e_taken = !(n || z);
                5'd6:  e_taken = n || z;
                5'd7:  e_taken = !n;
                5'd8:  e_taken = n;
                5'd9:  e_taken = !(c || z);
                5'd10: e_taken = c || z;
                5'd11: e_taken = !v;
                5'd12: e_taken = v;
                5'd13: e_taken = !c;
                5'd14: e_taken = c;
                5'd15: e_taken = idx[0];
                5'd16: e_taken = !idx[0];
                default: e_taken = 1'b0;
            endcase
        end
        e_pc = e_taken ? pc + disp : pc;
    endtask

    task automatic run(input logic [4:0] op, input logic [1:0] sz, input logic [3:0] cc,
                       input logic [31:0] idx, input logic [31:0] stp, input logic [31:0] lim,
                       input logic [31:0] disp, input logic [31:0] pc, input string tag);
        model(op, sz, cc, idx, stp, lim, disp, pc);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_size = sz; in_cc = cc; in_index = idx;
        in_step = stp; in_limit = lim; in_disp = disp; in_pc = pc;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, "R1 valid", out_valid, 1);
        check(out_taken === e_taken, {tag, " taken"}, out_taken, e_taken);
        check(out_next_pc === e_pc, "R11 next_pc", out_next_pc, e_pc);
        check(out_index === e_idx, {tag, " R4 index"}, out_index, e_idx);
        check(out_cc === e_cc, {tag, " flags"}, out_cc, e_cc);
        check(out_ovf === e_ovf, "R5 ovf", out_ovf, e_ovf);
    endtask

    initial begin
        #750000;
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int bv[9] = '{-128, -127, -2, -1, 0, 1, 2, 126, 127};
        int wv[6] = '{-32768, -1, 0, 1, 5, 32767};
        logic [31:0] lv[6] = '{32'h8000_0000, 32'h7fff_ffff, 32'h0, 32'h1, 32'hffff_ffff, 32'd1000};
        logic [31:0] hold_idx;
        repeat (3) @(negedge clk);
        // R12: reset state
        check(out_valid === 0 && out_taken === 0 && out_ovf === 0, "R12 reset ctl", out_valid, 0);
        check(out_next_pc === 0 && out_index === 0 && out_cc === 0, "R12 reset data", out_index, 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid === 0, "R1 no strobe", out_valid, 0);

        // R7 R8 R9 R10: every flag op under every flag pattern
        for (int op = 3; op <= 16; op++)
            for (int k = 0; k < 16; k++)
                run(5'(op), 2'(k % 3), 4'(k), 32'(k * 37 + op), 32'(k), 32'(op),
                    (k[0] ? 32'hffff_fff0 : 32'h40), 32'h1000 + 32'(k * 4),
                    (op <= 8) ? "R7 R10" : (op <= 14) ? "R8 R10" : "R9 R10");

        // R2 R3 R4 R5 R6: byte grid with junk in upper operand bits
        for (int op = 0; op <= 2; op++)
            for (int a = 0; a < 9; a++)
                for (int b = 0; b < 9; b++)
                    for (int l = 0; l < 9; l++)
                        run(5'(op), 2'd0, 4'((a + b + l) % 16),
                            {24'hA5A5A5, 8'(bv[a])}, {24'h5A5A5A, 8'(bv[b])},
                            {24'hC3C3C3, 8'(bv[l])}, 32'hffff_ff00, 32'h2000,
                            (op == 0) ? "R2 R6 byte" : "R3 R6 byte");

        // word width
        for (int op = 0; op <= 2; op++)
            for (int a = 0; a < 6; a++)
                for (int b = 0; b < 6; b++)
                    for (int l = 0; l < 6; l++)
                        run(5'(op), 2'd1, 4'((a * 3 + l) % 16),
                            {16'h1234, 16'(wv[a])}, {16'hfedc, 16'(wv[b])},
                            {16'h8001, 16'(wv[l])}, 32'h10, 32'h3000,
                            (op == 0) ? "R2 R5 word" : "R3 R5 word");

        // longword width
        for (int op = 0; op <= 2; op++)
            for (int a = 0; a < 6; a++)
                for (int b = 0; b < 6; b++)
                    for (int l = 0; l < 6; l++)
                        run(5'(op), 2'd2, 4'((a + l * 5) % 16), lv[a], lv[b], lv[l],
                            32'h8000_0000, 32'hffff_fff0,
                            (op == 0) ? "R2 R5 long" : "R3 R5 long");

        // R12: reserved codes
        for (int op = 17; op < 32; op++)
            run(5'(op), 2'd2, 4'hF, 32'h7fff_ffff, 32'h1, 32'h0, 32'h100, 32'h4000, "R12 reserved");

        // R1: outputs hold while no strobe, even as inputs move
        run(5'd0, 2'd2, 4'h1, 32'd5, 32'd1, 32'd9, 32'd8, 32'h500, "R2 R1 base");
        hold_idx = out_index;
        in_index = 32'hdead; in_op = 5'd4; in_pc = 32'h0; in_cc = 4'h0;
        repeat (3) @(negedge clk);
        check(out_index === hold_idx && out_taken === 1'b1, "R1 hold index", out_index, hold_idx);
        check(out_next_pc === 32'h508 && out_cc === 4'h1, "R1 hold pc", out_next_pc, 32'h508);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule